// File: doc/BRIEF.md
# Peripheral Register Page Selector

This block is an 8-bit control register that picks which page of a peripheral's banked registers the CPU sees. Its 3-bit page value drives the peripheral's register address decoder directly. Software writes the register over a simple register-bus port (write enable, read enable, 8-bit data). The upper bits of each write carry a command that says how the page changes.

Four 3-bit storage slots let a short routine change pages without reading the old page first. An interrupt handler enters with one write. That write loads its own page and parks the interrupted page in a slot it names. The handler leaves with a second write that pulls the parked page back. In the leaving write, any page bits it carries are discarded. Plain page writes that ignore the slots are also supported.

Top module: `pgsel_reg`

## Requirements
- R1: After synchronous reset, the page output is 0 and every storage slot holds 0. A read returns 00h.
- R2: While rd_en is high, rdata carries the active page in bits [2:0] and zeros in bits [7:3]. The command and slot-select fields therefore always read 0. While rd_en is low, rdata is 00h.
- R3: A write with wdata[7:6] = 00 or 01 loads wdata[2:0] into the page. The slot selector wdata[5:4] is ignored, and no slot changes.
- R4: A write with wdata[7:6] = 10 loads wdata[2:0] into the page. On the same edge it copies the page value that was active before the write into the slot selected by wdata[5:4].
- R5: A write with wdata[7:6] = 11 loads the page from the slot selected by wdata[5:4] and ignores wdata[2:0]. The slot keeps its content, so the same slot can be restored repeatedly.
- R6: Slot selector codes 00, 01, 10 and 11 address slots 0, 1, 2 and 3. Each slot is saved and restored independently of the others.
- R7: The page output changes on the clock edge that samples wr_en high. It is already valid in the cycle after the write.
- R8: With wr_en low, the page and the slots hold their values whatever wdata carries.
- R9: Bit 3 of wdata has no effect on any operation.
- R10: Asserting rd_en changes neither the page nor the slots.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe for one cycle |
| rd_en | input | 1 | Register read strobe |
| wdata | input | 8 | Write data: command [7:6], slot select [5:4], page [2:0] |
| rdata | output | 8 | Read data, zero when rd_en is low |
| page_out | output | 3 | Active page to the banked register decoder |

## Verification
The properties assume that wr_en, rd_en and wdata carry known values on every sampled edge outside reset. They also assume that wr_en is a single-cycle strobe whose data is valid on the same edge. The stimulus meets these assumptions by changing inputs only on the falling clock edge, holding wr_en low through reset, and dropping wr_en after each write. The sequence sets the reserved bit and the ignored page bits deliberately, so the assertions see each command code with both values of the don't-care fields.

// File: rtl/pgsel_pkg.sv
package pgsel_pkg;

    // Geometry of the register; field positions are decoded by software.
    localparam int REG_W      = 8;
    localparam int PAGE_W     = 3;
    localparam int SLOT_N     = 4;
    localparam int SLOT_SEL_W = $clog2(SLOT_N);
    localparam int OPC_W      = 2;
    localparam int PAGE_LSB   = 0;
    localparam int SEL_LSB    = 4;
    localparam int OPC_LSB    = 6;

    // Command code carried in the top bits of a write
    typedef enum logic [OPC_W-1:0] {
        OPC_LOAD_A = 2'b00,
        OPC_LOAD_B = 2'b01,
        OPC_PUSH   = 2'b10,
        OPC_POP    = 2'b11
    } opc_e;

    // Internal action after decoding
    typedef enum logic [1:0] {
        ACT_IDLE,
        ACT_LOAD,
        ACT_PUSH,
        ACT_POP
    } act_e;

    typedef struct packed {
        act_e                  act;
        logic [SLOT_SEL_W-1:0] slot;
        logic [PAGE_W-1:0]     page;
    } cmd_t;

    function automatic cmd_t decode_cmd(input logic wr, input logic [REG_W-1:0] d);
        cmd_t c;
        c.slot = d[SEL_LSB +: SLOT_SEL_W];
        c.page = d[PAGE_LSB +: PAGE_W];
        c.act  = ACT_IDLE;
        if (wr) begin
            case (opc_e'(d[OPC_LSB +: OPC_W]))
                OPC_PUSH: c.act = ACT_PUSH;
                OPC_POP:  c.act = ACT_POP;
                default:  c.act = ACT_LOAD;
            endcase
        end
        return c;
    endfunction

    // Readback: page in the low bits, everything else zero
    function automatic logic [REG_W-1:0] format_read(input logic [PAGE_W-1:0] p);
        logic [REG_W-1:0] r;
        r = '0;
        r[PAGE_LSB +: PAGE_W] = p;
        return r;
    endfunction

endpackage

// File: rtl/pgsel_decode.sv
module pgsel_decode
    import pgsel_pkg::*;
(
    input  logic             wr_en,
    input  logic [REG_W-1:0] wdata,
    output cmd_t             cmd
);

    always_comb begin
        cmd = decode_cmd(wr_en, wdata);
    end

endmodule

// File: rtl/pgsel_slots.sv
module pgsel_slots #(
    parameter int N_SLOTS = 4,
    parameter int WIDTH   = 3,
    localparam int SEL_W  = $clog2(N_SLOTS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push_en,
    input  logic [SEL_W-1:0] sel,
    input  logic [WIDTH-1:0] push_val,
    output logic [WIDTH-1:0] pop_val
);

    logic [WIDTH-1:0] slot_q [N_SLOTS];

    for (genvar i = 0; i < N_SLOTS; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                slot_q[i] <= '0;
            end else if (push_en && (sel == SEL_W'(i))) begin
                slot_q[i] <= push_val;
            end
        end
    end

    always_comb begin
        pop_val = slot_q[sel];
    end

endmodule

// File: rtl/pgsel_reg.sv
module pgsel_reg
    import pgsel_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    output logic [2:0]        page_out
);

    cmd_t              cmd;
    logic [PAGE_W-1:0] page_q;
    logic [PAGE_W-1:0] page_d;
    logic [PAGE_W-1:0] slot_val;
    logic              push_en;

    pgsel_decode u_dec (
        .wr_en (wr_en),
        .wdata (wdata),
        .cmd   (cmd)
    );

    assign push_en = (cmd.act == ACT_PUSH);

    pgsel_slots #(
        .N_SLOTS (SLOT_N),
        .WIDTH   (PAGE_W)
    ) u_slots (
        .clk      (clk),
        .rst      (rst),
        .push_en  (push_en),
        .sel      (cmd.slot),
        .push_val (page_q),
        .pop_val  (slot_val)
    );

    always_comb begin
        unique case (cmd.act)
            ACT_LOAD, ACT_PUSH: page_d = cmd.page;
            ACT_POP:            page_d = slot_val;
            default:            page_d = page_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            page_q <= '0;
        end else begin
            page_q <= page_d;
        end
    end

    assign page_out = page_q;
    assign rdata    = rd_en ? format_read(page_q) : '0;

endmodule

// File: rtl/pgsel_chk.sv
module pgsel_chk (
    input logic       clk,
    input logic       rst,
    input logic       wr_en,
    input logic       rd_en,
    input logic [7:0] wdata,
    input logic [7:0] rdata,
    input logic [2:0] page_out
);

    // R3
    load_page_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wdata[7]) |=> (page_out == $past(wdata[2:0])));

    // R4
    push_page_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wdata[7:6] == 2'b10) |=> (page_out == $past(wdata[2:0])));

    // R8
    hold_page_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(page_out));

    // R2
    read_fmt_chk: assert property (@(posedge clk) disable iff (rst)
        rd_en |-> (rdata == {5'b00000, page_out}));

    // R2
    read_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_en |-> (rdata == 8'h00));

    // R1
    reset_page_chk: assert property (@(posedge clk)
        $fell(rst) |-> (page_out == 3'd0));

endmodule

bind pgsel_reg pgsel_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .wdata    (wdata),
    .rdata    (rdata),
    .page_out (page_out)
);

// File: tb/tb_pgsel_reg.sv
`timescale 1ns/1ps
module tb_pgsel_reg;

    logic       clk = 1'b0;
    logic       rst;
    logic       wr_en;
    logic       rd_en;
    logic [7:0] wdata;
    logic [7:0] rdata;
    logic [2:0] page_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    pgsel_reg dut (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .rd_en    (rd_en),
        .wdata    (wdata),
        .rdata    (rdata),
        .page_out (page_out)
    );

    typedef struct packed {
        logic [7:0] wd;
        logic [2:0] exp_page;
        logic [3:0] req;
    } vec_t;

    // Command [7:6]: 0x load, 10 save old page to slot [5:4], 11 restore from slot [5:4]
    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{8'h05, 3'd5, 4'd3},  // R3 op 00
        '{8'h42, 3'd2, 4'd3},  // R3 op 01
        '{8'h83, 3'd3, 4'd4},  // R4 slot0 <- 2
        '{8'h97, 3'd7, 4'd4},  // R4 slot1 <- 3
        '{8'hA1, 3'd1, 4'd6},  // R6 slot2 <- 7
        '{8'hB4, 3'd4, 4'd6},  // R6 slot3 <- 1
        '{8'hC6, 3'd2, 4'd5},  // R5 restore slot0, page bits ignored
        '{8'hD0, 3'd3, 4'd6},  // R6 restore slot1
        '{8'hE5, 3'd7, 4'd6},  // R6 restore slot2
        '{8'hF2, 3'd1, 4'd6},  // R6 restore slot3
        '{8'hC7, 3'd2, 4'd5},  // R5 slot0 restored again
        '{8'h0E, 3'd6, 4'd9},  // R9 bit 3 set
        '{8'h70, 3'd0, 4'd3},  // R3 selector 11 ignored
        '{8'hF0, 3'd1, 4'd3}   // R3 slot3 untouched by load
    };

    task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1;
        wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    initial begin
        #200000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; wr_en = 1'b0; rd_en = 1'b0; wdata = 8'h00;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state and readback
        rd_en = 1'b1;
        check8("R1 page", {5'b0, page_out}, 8'h00);
        check8("R1 read", rdata, 8'h00);
        rd_en = 1'b0;
        // R1 slots reset to zero
        do_write(8'h03);
        do_write(8'hE6);
        check8("R1 slot2", {5'b0, page_out}, 8'h00);

        // Vector table
        for (int i = 0; i < NV; i++) begin
            do_write(VECS[i].wd);
            check8($sformatf("R%0d vec%0d", VECS[i].req, i), {5'b0, page_out}, {5'b0, VECS[i].exp_page});
        end

        // R2 readback formatting with fields set in the last write
        do_write(8'hAD);
        rd_en = 1'b1;
        #0.1;
        check8("R2 read fmt", rdata, 8'h05);
        rd_en = 1'b0;
        #0.1;
        check8("R2 read idle", rdata, 8'h00);

        // R7 page changes exactly at the accepting edge
        @(negedge clk);
        wr_en = 1'b1; wdata = 8'h02;
        #1;
        check8("R7 before edge", {5'b0, page_out}, 8'h05);
        @(posedge clk);
        #1;
        check8("R7 after edge", {5'b0, page_out}, 8'h02);
        @(negedge clk);
        wr_en = 1'b0;

        // R8 no write strobe: page and slots hold
        wdata = 8'hB7;
        repeat (3) @(negedge clk);
        check8("R8 page hold", {5'b0, page_out}, 8'h02);
        do_write(8'hF0);   // slot3 still holds 1 from table
        check8("R8 slot hold", {5'b0, page_out}, 8'h01);

        // R10 read strobe has no side effect
        rd_en = 1'b1; wdata = 8'h86;
        repeat (4) @(negedge clk);
        check8("R10 page", rdata, 8'h01);
        rd_en = 1'b0;
        do_write(8'hD0);   // slot1 still 3
        check8("R10 slot", {5'b0, page_out}, 8'h03);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule